// File: doc/BRIEF.md
# Two-Level Microprogrammed Control Sequencer

This block is the control unit of a microprogrammed engine that keeps its control in two stored levels. An opcode arrives with a valid strobe. A decoder turns it into a starting address in a narrow vertical micro-store, and it does no sequencing of its own. Each micro-word gives a sequencing type, a branch or jump target, a flag selector and an index into a wide horizontal nano-store. The nano-word that the index picks is driven out as the raw control lines of the datapath.

The nano-store is much smaller than the micro-store (16 words against 64), so several micro-words can point at one nano-word. A conditional branch on a selected flag lets a routine loop over a step until a datapath condition ends it, which is how long operations such as multiply or divide are built. Opcodes that have no decoder entry are sent to a dedicated illegal-instruction routine.

The micro-address register updates on every clock. The control word registered from the current micro-word appears on the output one cycle later. Branch decisions are taken on the flags present while the micro-word is current.

Top module: `tl_ctrl_seq`

## Requirements
- R1: After reset the sequencer sits at the idle micro-address. `ctrl_out` is all zero and `instr_done` is low, and it stays there for as long as `op_valid` is low.
- R2: Nano-word k drives `ctrl_out` = {k[3:0], ~k[3:0], 8'h01 << k[2:0]} for k ≥ 1 and zero for k = 0. The control word of a micro-word appears on `ctrl_out` in the cycle after that micro-word is current. Opcode 4'h1 runs nano-words 1 then 2.
- R3: Opcode 4'h2 runs its own micro-words but shares nano-words 1 and 2. Its `ctrl_out` sequence is therefore the same as that of opcode 4'h1.
- R4: `instr_done` is high for exactly one cycle: the cycle in which the final micro-word of a routine is current. That is one cycle before the final control word appears on `ctrl_out`.
- R5: Opcode 4'h3 runs nano-word 3 and then jumps over a micro-address to a final step with nano-word 4.
- R6: Opcode 4'h5 runs nano-word 9 and then branches on flags[2]. When flags[2] is 1 it ends with nano-word 11. When flags[2] is 0 it ends with nano-word 10. Other flag bits have no effect.
- R7: Opcode 4'h4 runs nano-word 5, then repeats the body (nano-word 6, nano-word 7) while flags[0] is 0 at the test step (nano-word 6). It ends with nano-word 8 once flags[0] is 1.
- R8: Opcodes 4'h0 and 4'h6 to 4'hF have no decoder entry. They run the illegal-instruction routine, nano-words 12 then 13.
- R9: `op_valid` is ignored while a routine is running. It is accepted only at the idle address or in the `instr_done` cycle.
- R10: An opcode presented in the `instr_done` cycle starts its routine on the next clock, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 4 | Instruction opcode |
| flags | input | 4 | Datapath condition flags |
| ctrl_out | output | 16 | Horizontal control lines (registered nano-word) |
| instr_done | output | 1 | Final micro-step of the current routine |

## Verification
The bench follows the one-cycle lag between the micro-address and the control output on every step. A sequencer that dropped or doubled that pipeline stage would shift every control word by a cycle.

The loop test holds flags[0] low for two passes and then raises it. This catches a branch with reversed sense, or one that samples the wrong cycle, which would exit early or spin past the end. The branch test also sets flags[0] while the selector points at flags[2], so a wrong flag selector is caught.

Further tests present an opcode mid-routine and an opcode in the done cycle. A sequencer that accepted opcodes at any time would abort routines, and one that inserted an idle cycle would delay chained instructions. Undecoded opcodes must land in the illegal routine and not wander to address zero.

// File: rtl/tl_pkg.sv
package tl_pkg;
  parameter int OPC_W  = 4;
  parameter int UA_W   = 6;
  parameter int NI_W   = 4;
  parameter int CTRL_W = 16;
  parameter int FLAG_N = 4;

  localparam int FSEL_W = $clog2(FLAG_N);
  localparam int UDEPTH = 1 << UA_W;
  localparam int NDEPTH = 1 << NI_W;

  typedef enum logic [1:0] {
    SQ_CONT = 2'd0,
    SQ_CBR  = 2'd1,
    SQ_JUMP = 2'd2,
    SQ_END  = 2'd3
  } sq_e;

  typedef struct packed {
    sq_e               sq;
    logic [FSEL_W-1:0] fsel;
    logic [UA_W-1:0]   nxt;
    logic [NI_W-1:0]   nidx;
  } uword_t;

  localparam logic [UA_W-1:0] IDLE_UA = UA_W'(0);
  localparam logic [UA_W-1:0] ILL_UA  = UA_W'(20);

  function automatic uword_t mk(sq_e s, int f, int n, int k);
    uword_t w;
    w.sq   = s;
    w.fsel = FSEL_W'(f);
    w.nxt  = UA_W'(n);
    w.nidx = NI_W'(k);
    return w;
  endfunction

  // vertical micro-program
  function automatic uword_t ucode_at(int a);
    case (a)
      0:       return mk(SQ_END,  0, 0,  0);  // idle
      1:       return mk(SQ_CONT, 0, 0,  1);
      2:       return mk(SQ_END,  0, 0,  2);
      3:       return mk(SQ_CONT, 0, 0,  1);  // shares nano 1
      4:       return mk(SQ_END,  0, 0,  2);  // shares nano 2
      5:       return mk(SQ_JUMP, 0, 8,  3);
      8:       return mk(SQ_END,  0, 0,  4);
      10:      return mk(SQ_CONT, 0, 0,  5);
      11:      return mk(SQ_CBR,  0, 13, 6);  // loop test on flag 0
      12:      return mk(SQ_JUMP, 0, 11, 7);
      13:      return mk(SQ_END,  0, 0,  8);
      14:      return mk(SQ_CBR,  2, 16, 9);
      15:      return mk(SQ_END,  0, 0,  10);
      16:      return mk(SQ_END,  0, 0,  11);
      20:      return mk(SQ_CONT, 0, 0,  12); // illegal routine
      21:      return mk(SQ_END,  0, 0,  13);
      default: return mk(SQ_JUMP, 0, 20, 0);
    endcase
  endfunction

  // horizontal nano-word contents
  function automatic logic [CTRL_W-1:0] nano_at(int k);
    logic [3:0] kk;
    logic [7:0] oh;
    kk = 4'(k);
    oh = 8'h01 << kk[2:0];
    if (k == 0) return '0;
    return CTRL_W'({kk, ~kk, oh});
  endfunction
endpackage

// File: rtl/tl_decode.sv
module tl_decode
  import tl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output logic [UA_W-1:0]  entry,
  output logic             hit
);
  always_comb begin
    hit   = 1'b1;
    entry = ILL_UA;
    case (opcode)
      OPC_W'(1): entry = UA_W'(1);
      OPC_W'(2): entry = UA_W'(3);
      OPC_W'(3): entry = UA_W'(5);
      OPC_W'(4): entry = UA_W'(10);
      OPC_W'(5): entry = UA_W'(14);
      default: begin
        hit   = 1'b0;
        entry = ILL_UA;
      end
    endcase
  end
endmodule

// File: rtl/tl_ustore.sv
module tl_ustore
  import tl_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output uword_t          word
);
  uword_t rom [UDEPTH];

  for (genvar g = 0; g < UDEPTH; g++) begin : g_urom
    assign rom[g] = ucode_at(g);
  end

  assign word = rom[addr];
endmodule

// File: rtl/tl_nstore.sv
module tl_nstore
  import tl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [NI_W-1:0]   idx,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] rom [NDEPTH];
  logic [CTRL_W-1:0] ctrl_d;

  for (genvar g = 0; g < NDEPTH; g++) begin : g_nrom
    assign rom[g] = nano_at(g);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (en) ctrl_d = rom[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/tl_ctrl_seq.sv
module tl_ctrl_seq
  import tl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FLAG_N-1:0] flags,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic              instr_done
);
  logic            rs_meta, rs_n;
  logic [UA_W-1:0] uaddr_q, uaddr_d;
  logic [UA_W-1:0] entry;
  logic            dec_hit;
  logic            at_idle, dispatch;
  uword_t          uw;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  tl_decode u_dec (.opcode(opcode), .entry(entry), .hit(dec_hit));
  tl_ustore u_us  (.addr(uaddr_q), .word(uw));
  tl_nstore u_ns  (.clk(clk), .rst_n(rs_n), .en(1'b1), .idx(uw.nidx), .ctrl_q(ctrl_out));

  assign at_idle    = (uaddr_q == IDLE_UA);
  assign dispatch   = at_idle || (uw.sq == SQ_END);
  assign instr_done = (uw.sq == SQ_END) && !at_idle;

  always_comb begin
    uaddr_d = IDLE_UA;
    if (dispatch) begin
      uaddr_d = op_valid ? entry : IDLE_UA;
    end else begin
      case (uw.sq)
        SQ_CONT: uaddr_d = uaddr_q + UA_W'(1);
        SQ_CBR:  uaddr_d = flags[uw.fsel] ? uw.nxt : uaddr_q + UA_W'(1);
        SQ_JUMP: uaddr_d = uw.nxt;
        default: uaddr_d = IDLE_UA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) uaddr_q <= IDLE_UA;
    else       uaddr_q <= uaddr_d;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rs_n)
    (at_idle && !op_valid) |=> (at_idle && ctrl_out == '0)); // R1
  AST_DISPATCH_ENTRY: assert property (@(posedge clk) disable iff (!rs_n)
    (dispatch && op_valid && dec_hit) |=> (uaddr_q == $past(entry))); // R2
  AST_ILLEGAL_VECTOR: assert property (@(posedge clk) disable iff (!rs_n)
    (dispatch && op_valid && !dec_hit) |=> (uaddr_q == ILL_UA)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rs_n)
    instr_done |=> !instr_done); // R4
  AST_BUSY_IGNORES_VALID: assert property (@(posedge clk) disable iff (!rs_n)
    (!dispatch && uw.sq == SQ_CONT) |=> (uaddr_q == $past(uaddr_q) + UA_W'(1))); // R9
endmodule

// File: tb/tl_ctrl_seq_bench.sv
module tl_ctrl_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [3:0]  flags = 4'h0;
  logic [15:0] ctrl_out;
  logic        instr_done;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  tl_ctrl_seq u_tl_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .flags(flags), .ctrl_out(ctrl_out), .instr_done(instr_done)
  );

  function automatic logic [15:0] nw(int k);
    logic [3:0] kk;
    kk = 4'(k);
    if (k == 0) return 16'h0;
    return {kk, ~kk, 8'h01 << kk[2:0]};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cyc(input logic ed, input int k, input string tag);
    n_chk++;
    if (instr_done !== ed) begin
      n_bad++;
      $display("FAIL %s done actual=%b expected=%b", tag, instr_done, ed);
    end
    n_chk++;
    if (ctrl_out !== nw(k)) begin
      n_bad++;
      $display("FAIL %s ctrl actual=%h expected=%h", tag, ctrl_out, nw(k));
    end
  endtask

  task automatic issue(input logic [3:0] op);
    op_valid = 1'b1;
    opcode = op;
    tick();
    op_valid = 1'b0;
  endtask

  task automatic two_step(input logic [3:0] op, input int a, input int b, input string tag);
    issue(op);
    cyc(1'b0, 0, tag);
    tick(); cyc(1'b1, a, tag);
    tick(); cyc(1'b0, b, tag);
    tick(); cyc(1'b0, 0, tag);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      tick(); cyc(1'b0, 0, "R1 idle");
    end
  endtask

  task automatic t_branch(input logic f2, input int last);
    flags = f2 ? 4'b0100 : 4'b0001;
    issue(4'h5);
    cyc(1'b0, 0, "R6 br");
    tick(); cyc(1'b1, 9, "R6 br");
    tick(); cyc(1'b0, last, "R6 br");
    flags = 4'h0;
    tick();
  endtask

  task automatic t_loop();
    flags = 4'h0;
    issue(4'h4);
    cyc(1'b0, 0, "R7 loop");                 // word 10 current
    tick(); cyc(1'b0, 5, "R7 loop");          // word 11, flag0=0
    tick(); cyc(1'b0, 6, "R7 loop");          // word 12
    op_valid = 1'b1; opcode = 4'h1;           // R9 must be ignored
    tick(); cyc(1'b0, 7, "R9 busy");          // word 11 again
    op_valid = 1'b0;
    flags = 4'h0;
    tick(); cyc(1'b0, 6, "R7 loop");          // word 12
    tick(); cyc(1'b0, 7, "R7 loop");          // word 11
    flags = 4'h1;
    tick(); cyc(1'b1, 6, "R7 loop");          // word 13 end
    flags = 4'h0;
    tick(); cyc(1'b0, 8, "R7 loop");
    tick(); cyc(1'b0, 0, "R7 loop");
  endtask

  task automatic t_chain();
    issue(4'h1);
    cyc(1'b0, 0, "R10 chain");
    tick(); cyc(1'b1, 1, "R10 chain");
    op_valid = 1'b1; opcode = 4'h3;
    tick(); op_valid = 1'b0;
    cyc(1'b0, 2, "R10 chain");
    tick(); cyc(1'b1, 3, "R10 chain");
    tick(); cyc(1'b0, 4, "R10 chain");
    tick(); cyc(1'b0, 0, "R10 chain");
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    two_step(4'h1, 1, 2, "R2 op1");
    two_step(4'h2, 1, 2, "R3 shared");
    two_step(4'h3, 3, 4, "R5 jump");
    t_branch(1'b1, 11);
    t_branch(1'b0, 10);
    t_loop();
    two_step(4'h9, 12, 13, "R8 illegal");
    two_step(4'h0, 12, 13, "R8 illegal0");
    t_chain();
    tick(); cyc(1'b0, 0, "R4 quiet");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule